// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a chip and turns I/O port cycles into configuration-space transactions. Software first writes a 32-bit selector word to an address port. The word names the target bus, device and function, the dword register index, and a global enable. A later access to the data port then starts one configuration read or write on a simple request/response channel toward the configuration target.

The host may use byte, halfword or dword accesses on the data port. Downstream traffic is always a whole aligned dword. For reads, the bridge fetches the dword and returns only the addressed lanes, shifted down to bit 0. For byte and halfword writes, the bridge fetches the current dword, replaces only the addressed lanes with the new value, and writes the whole dword back. The bytes it does not address keep their old contents.

Every accepted access to either port ends with a one-cycle completion pulse that carries read data and an error flag. The host issues a new access only while the busy output is low. An access offered while busy is high is ignored.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, busy, done and the downstream request valid are all 0, and a dword read of the address port returns 0.
- R2: A dword write at I/O 0x0CF8 stores the selector word. Bit 31 is the enable, bits 23:16 the bus, bits 15:11 the device, bits 10:8 the function and bits 7:2 the register index. A read of 0x0CF8 returns the stored word with bits 30:24 and 1:0 as zero. Downstream requests carry the bus, device, function and register index from the stored word.
- R3: With the enable set, a dword read at 0x0CFC issues one downstream read and returns the target's dword unchanged. Data is little-endian: byte lane k is bits 8k+7:8k.
- R4: A byte read at 0x0CFC+k (k = 0..3) returns bits 8k+7:8k of the target dword, zero-extended.
- R5: A halfword read at 0x0CFC+k returns bits 15:0 when k[1] = 0 and bits 31:16 when k[1] = 1, zero-extended. Address bit 0 has no effect.
- R6: A dword write at 0x0CFC issues exactly one downstream write carrying the host data unchanged, and no read.
- R7: A byte or halfword write issues one downstream read and then one downstream write. The written dword equals the old dword with only the addressed lanes replaced by the low 8 or 16 bits of the host data. Lane selection follows R4/R5, and the higher host data bits have no effect.
- R8: While the enable is clear, a data-port read completes with data 0xFFFFFFFF. A data-port write completes with no effect. Neither issues a downstream request.
- R9: The following complete with err = 1 and read data 0, issue no downstream request, and leave the stored selector unchanged: any access to 0x0CF8..0x0CFB that is not a dword at 0x0CF8; a dword access at 0x0CFD..0x0CFF; any access with size code 3. Size codes are 0 byte, 1 halfword, 2 dword.
- R10: Busy is high from the cycle after an access that needs the target is accepted until its completion. Any access offered while busy is high is ignored: it produces no completion, no request and no state change.
- R11: A downstream request, once valid, stays valid with unchanged write flag, fields and data until the target accepts it with ready.
- R12: Accesses outside 0x0CF8..0x0CFF are ignored. They produce no completion, no request and no change to the stored selector.
- R13: Three kinds of completion are due one cycle after a specific event. Address-port, disabled and error completions are due one cycle after acceptance. A read completion is due one cycle after the target's response. A write completion is due one cycle after the downstream write handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host offers an I/O access this cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 16 | I/O byte address |
| hst_size | input | 2 | 0 byte, 1 halfword, 2 dword, 3 invalid |
| hst_wdata | input | 32 | Write value, right-justified |
| hst_busy | output | 1 | A transaction is in progress; new accesses are ignored |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_err | output | 1 | Completion flags a rejected access |
| hst_rdata | output | 32 | Read data, right-justified, valid with done |
| cfg_req_valid | output | 1 | Downstream request valid |
| cfg_req_ready | input | 1 | Target accepts the request |
| cfg_req_write | output | 1 | Request is a dword write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_dev | output | 5 | Target device number |
| cfg_req_func | output | 3 | Target function number |
| cfg_req_reg | output | 6 | Target dword register index |
| cfg_req_wdata | output | 32 | Dword to write |
| cfg_rsp_valid | input | 1 | Read response valid |
| cfg_rsp_rdata | input | 32 | Read response dword |

## Verification
Completions for the address port, the disabled case and errors are due one cycle after the accepting edge. A read completion is due one cycle after the target's response. A write completion, including the tail of a read-modify-write, is due one cycle after the write handshake. The bench records which of these three events happened at each rising edge. Each expected item in the scoreboard names the event it must follow, so a completion that arrives early, late or unasked for is reported. The target model answers reads one cycle after the handshake and can withhold ready, which stretches the request phases. The bench checks at falling edges that a stalled request keeps its contents.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 6;
    localparam int EN_BIT  = 31;
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int REG_LSB = 2;

    // Bits of the selector word that are stored; all others read as zero.
    localparam logic [DATA_W-1:0] SEL_KEEP =
        (32'd1 << EN_BIT)
        | (((32'd1 << BUS_W) - 32'd1) << BUS_LSB)
        | (((32'd1 << DEV_W) - 32'd1) << DEV_LSB)
        | (((32'd1 << FN_W)  - 32'd1) << FN_LSB)
        | (((32'd1 << REG_W) - 32'd1) << REG_LSB);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RREQ  = 2'd1,
        ST_RWAIT = 2'd2,
        ST_WREQ  = 2'd3
    } state_e;

    typedef struct packed {
        state_e              st;
        logic                done;
        logic                err;
        logic [DATA_W-1:0]   rdata;
        logic [DATA_W-1:0]   sel;
        size_e               size;
        logic [1:0]          off;
        logic                wr;
        logic [DATA_W-1:0]   wbuf;
    } ctrl_s;

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfg_bridge_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic [IO_AW-1:0] io_addr,
    input  size_e            io_size,
    output logic             hit_addr,
    output logic             hit_data,
    output logic             bad,
    output logic [1:0]       off
);

    logic addr_bad;
    logic data_bad;

    always_comb begin
        hit_addr = (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
        hit_data = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
        off      = io_addr[1:0];
        addr_bad = (io_size != SZ_WORD) || (off != 2'd0);
        data_bad = (io_size == SZ_RSVD) || ((io_size == SZ_WORD) && (off != 2'd0));
        bad      = (hit_addr && addr_bad) || (hit_data && data_bad);
    end

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import cfg_bridge_pkg::*;
(
    input  logic [DATA_W-1:0] old_dw,
    input  size_e             size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] merged
);

    logic [LANES-1:0] lane_sel;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [1:0] KI = 2'(k);
        logic [7:0] src;

        always_comb begin
            lane_sel[k] = (size == SZ_WORD)
                        || ((size == SZ_BYTE) && (off == KI))
                        || ((size == SZ_HALF) && (off[1] == KI[1]));
            case (size)
                SZ_BYTE: src = new_val[7:0];
                SZ_HALF: src = new_val[8*(k%2) +: 8];
                default: src = new_val[8*k +: 8];
            endcase
        end

        assign merged[8*k +: 8] = lane_sel[k] ? src : old_dw[8*k +: 8];
    end

    always_comb begin
        case (size)
            SZ_BYTE: rd_val = {24'd0, 8'(old_dw >> {off, 3'b000})};
            SZ_HALF: rd_val = {16'd0, 16'(old_dw >> {off[1], 4'b0000})};
            default: rd_val = old_dw;
        endcase
    end

endmodule

// File: rtl/cfg_bridge_ctrl.sv
module cfg_bridge_ctrl
    import cfg_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_valid,
    input  logic              hst_write,
    input  size_e             hst_size,
    input  logic [1:0]        hst_off,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic              hit_addr,
    input  logic              hit_data,
    input  logic              bad,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] lane_rd,
    input  logic [DATA_W-1:0] lane_merged,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              req_valid,
    output logic              req_write,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] sel_word,
    output size_e             lat_size,
    output logic [1:0]        lat_off
);

    ctrl_s r_q;
    ctrl_s r_d;
    logic  accept_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        accept_d = hst_valid && (r_q.st == ST_IDLE) && (hit_addr || hit_data);

        case (r_q.st)
            ST_IDLE: begin
                if (accept_d) begin
                    if (bad) begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.rdata = '0;
                    end else if (hit_addr) begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.rdata = hst_write ? '0 : r_q.sel;
                        if (hst_write) begin
                            r_d.sel = hst_wdata & SEL_KEEP;
                        end
                    end else if (!r_q.sel[EN_BIT]) begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.rdata = hst_write ? '0 : '1;
                    end else begin
                        r_d.size = hst_size;
                        r_d.off  = hst_off;
                        r_d.wr   = hst_write;
                        r_d.wbuf = hst_wdata;
                        if (hst_write && (hst_size == SZ_WORD)) begin
                            r_d.st = ST_WREQ;
                        end else begin
                            r_d.st = ST_RREQ;
                        end
                    end
                end
            end
            ST_RREQ: begin
                if (req_ready) begin
                    r_d.st = ST_RWAIT;
                end
            end
            ST_RWAIT: begin
                if (rsp_valid) begin
                    if (r_q.wr) begin
                        r_d.wbuf = lane_merged;
                        r_d.st   = ST_WREQ;
                    end else begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.rdata = lane_rd;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            ST_WREQ: begin
                if (req_ready) begin
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b0;
                    r_d.rdata = '0;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, size: SZ_BYTE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign rdata     = r_q.rdata;
    assign req_valid = (r_q.st == ST_RREQ) || (r_q.st == ST_WREQ);
    assign req_write = (r_q.st == ST_WREQ);
    assign req_wdata = r_q.wbuf;
    assign sel_word  = r_q.sel;
    assign lat_size  = r_q.size;
    assign lat_off   = r_q.off;

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfg_bridge_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_valid,
    input  logic              hst_write,
    input  logic [IO_AW-1:0]  hst_addr,
    input  logic [1:0]        hst_size,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic              hst_busy,
    output logic              hst_done,
    output logic              hst_err,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              cfg_req_valid,
    input  logic              cfg_req_ready,
    output logic              cfg_req_write,
    output logic [BUS_W-1:0]  cfg_req_bus,
    output logic [DEV_W-1:0]  cfg_req_dev,
    output logic [FN_W-1:0]   cfg_req_func,
    output logic [REG_W-1:0]  cfg_req_reg,
    output logic [DATA_W-1:0] cfg_req_wdata,
    input  logic              cfg_rsp_valid,
    input  logic [DATA_W-1:0] cfg_rsp_rdata
);

    size_e             size_in;
    logic              hit_addr;
    logic              hit_data;
    logic              bad;
    logic [1:0]        off;
    logic [DATA_W-1:0] lane_rd;
    logic [DATA_W-1:0] lane_merged;
    logic [DATA_W-1:0] sel_word;
    size_e             lat_size;
    logic [1:0]        lat_off;
    logic              cfg_enabled;

    assign size_in = size_e'(hst_size);

    cfg_port_decode #(
        .IO_AW     (IO_AW),
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_dec (
        .io_addr  (hst_addr),
        .io_size  (size_in),
        .hit_addr (hit_addr),
        .hit_data (hit_data),
        .bad      (bad),
        .off      (off)
    );

    cfg_lane_unit u_lane (
        .old_dw  (cfg_rsp_rdata),
        .size    (lat_size),
        .off     (lat_off),
        .new_val (cfg_req_wdata),
        .rd_val  (lane_rd),
        .merged  (lane_merged)
    );

    cfg_bridge_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hst_valid   (hst_valid),
        .hst_write   (hst_write),
        .hst_size    (size_in),
        .hst_off     (off),
        .hst_wdata   (hst_wdata),
        .hit_addr    (hit_addr),
        .hit_data    (hit_data),
        .bad         (bad),
        .req_ready   (cfg_req_ready),
        .rsp_valid   (cfg_rsp_valid),
        .lane_rd     (lane_rd),
        .lane_merged (lane_merged),
        .busy        (hst_busy),
        .done        (hst_done),
        .err         (hst_err),
        .rdata       (hst_rdata),
        .req_valid   (cfg_req_valid),
        .req_write   (cfg_req_write),
        .req_wdata   (cfg_req_wdata),
        .sel_word    (sel_word),
        .lat_size    (lat_size),
        .lat_off     (lat_off)
    );

    assign cfg_enabled  = sel_word[EN_BIT];
    assign cfg_req_bus  = sel_word[BUS_LSB +: BUS_W];
    assign cfg_req_dev  = sel_word[DEV_LSB +: DEV_W];
    assign cfg_req_func = sel_word[FN_LSB +: FN_W];
    assign cfg_req_reg  = sel_word[REG_LSB +: REG_W];

endmodule

// File: rtl/cfg_bridge_chk.sv
module cfg_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hst_valid,
    input logic        hst_busy,
    input logic        hst_done,
    input logic        hit_addr,
    input logic        hit_data,
    input logic        cfg_enabled,
    input logic        cfg_req_valid,
    input logic        cfg_req_ready,
    input logic        cfg_req_write,
    input logic [5:0]  cfg_req_reg,
    input logic [7:0]  cfg_req_bus,
    input logic [31:0] cfg_req_wdata
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && !cfg_req_ready |=> cfg_req_valid);

    // R11
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && !cfg_req_ready |=> $stable(cfg_req_write) && $stable(cfg_req_wdata)
                                            && $stable(cfg_req_reg) && $stable(cfg_req_bus));

    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> hst_busy);

    // R8
    dis_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_valid && !hst_busy && hit_data && !cfg_enabled |=> !cfg_req_valid && hst_done);

    // R13
    aport_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_valid && !hst_busy && hit_addr |=> hst_done && !hst_busy);

endmodule

bind cfg_port_bridge cfg_bridge_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hst_valid     (hst_valid),
    .hst_busy      (hst_busy),
    .hst_done      (hst_done),
    .hit_addr      (hit_addr),
    .hit_data      (hit_data),
    .cfg_enabled   (cfg_enabled),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_ready (cfg_req_ready),
    .cfg_req_write (cfg_req_write),
    .cfg_req_reg   (cfg_req_reg),
    .cfg_req_bus   (cfg_req_bus),
    .cfg_req_wdata (cfg_req_wdata)
);

// File: tb/sim_cfg_port_bridge.sv
module sim_cfg_port_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_valid = 1'b0;
    logic        hst_write = 1'b0;
    logic [15:0] hst_addr = 16'h0;
    logic [1:0]  hst_size = 2'd0;
    logic [31:0] hst_wdata = 32'h0;
    logic        hst_busy, hst_done, hst_err;
    logic [31:0] hst_rdata;
    logic        cfg_req_valid, cfg_req_write;
    logic        cfg_req_ready = 1'b1;
    logic [7:0]  cfg_req_bus;
    logic [4:0]  cfg_req_dev;
    logic [2:0]  cfg_req_func;
    logic [5:0]  cfg_req_reg;
    logic [31:0] cfg_req_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic [31:0] cfg_rsp_rdata = 32'h0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cfg_port_bridge u0 (
        .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
        .hst_addr(hst_addr), .hst_size(hst_size), .hst_wdata(hst_wdata),
        .hst_busy(hst_busy), .hst_done(hst_done), .hst_err(hst_err), .hst_rdata(hst_rdata),
        .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
        .cfg_req_write(cfg_req_write), .cfg_req_bus(cfg_req_bus), .cfg_req_dev(cfg_req_dev),
        .cfg_req_func(cfg_req_func), .cfg_req_reg(cfg_req_reg), .cfg_req_wdata(cfg_req_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata)
    );

    function automatic logic [31:0] seed_val(input int i);
        return (i * 32'h0101_0101) ^ 32'h1357_9BDF;
    endfunction

    // target model
    logic [31:0] tmem [64];
    logic [31:0] exp_mem [64];
    int          req_cnt = 0;
    logic [7:0]  last_bus;
    logic [4:0]  last_dev;
    logic [2:0]  last_func;
    logic [5:0]  last_reg;
    bit          slow = 1'b0;
    int          rcyc = 0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            tmem[i]    = seed_val(i);
            exp_mem[i] = seed_val(i);
        end
    end

    always @(posedge clk) begin
        cfg_rsp_valid <= 1'b0;
        if (cfg_req_valid && cfg_req_ready) begin
            req_cnt   <= req_cnt + 1;
            last_bus  <= cfg_req_bus;
            last_dev  <= cfg_req_dev;
            last_func <= cfg_req_func;
            last_reg  <= cfg_req_reg;
            if (cfg_req_write) begin
                tmem[cfg_req_reg] <= cfg_req_wdata;
            end else begin
                cfg_rsp_valid <= 1'b1;
                cfg_rsp_rdata <= tmem[cfg_req_reg];
            end
        end
    end

    always @(posedge clk) begin
        #2;
        rcyc = rcyc + 1;
        cfg_req_ready = slow ? ((rcyc % 3) == 0) : 1'b1;
    end

    // event flags captured at each rising edge
    logic acc_edge = 1'b0, rsp_edge = 1'b0, whs_edge = 1'b0;
    always @(posedge clk) begin
        acc_edge <= hst_valid && !hst_busy && (hst_addr[15:3] == 13'h019F);
        rsp_edge <= cfg_rsp_valid;
        whs_edge <= cfg_req_valid && cfg_req_ready && cfg_req_write;
    end

    typedef struct {
        logic [31:0] rd;
        logic        er;
        int          late;
        string       tag;
    } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && hst_done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10/R12 unexpected completion", hst_rdata, 32'h0);
            end else begin
                exp_t e;
                logic evt;
                e = q.pop_front();
                chk(hst_rdata == e.rd, e.tag, hst_rdata, e.rd);
                chk(hst_err == e.er, e.tag, 32'(hst_err), 32'(e.er));
                evt = (e.late == 0) ? acc_edge : (e.late == 1) ? rsp_edge : whs_edge;
                chk(evt, {"R13 timing ", e.tag}, 32'(evt), 32'd1);
            end
        end
    end

    // R11: stalled request keeps its contents
    logic        pend = 1'b0;
    logic [31:0] pend_w;
    logic [5:0]  pend_r;
    logic        pend_wr;
    always @(negedge clk) begin
        if (rst_n && pend) begin
            chk(cfg_req_valid && cfg_req_write == pend_wr && cfg_req_wdata == pend_w
                && cfg_req_reg == pend_r, "R11 request held", cfg_req_wdata, pend_w);
        end
        pend    = rst_n && cfg_req_valid && !cfg_req_ready;
        pend_w  = cfg_req_wdata;
        pend_r  = cfg_req_reg;
        pend_wr = cfg_req_write;
    end

    task automatic acc(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input bit expd, input logic [31:0] er,
                       input logic ee, input int late, input string tag);
        exp_t e;
        if (expd) begin
            e.rd = er; e.er = ee; e.late = late; e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        while (hst_busy) @(negedge clk);
        hst_valid = 1'b1; hst_write = wr; hst_addr = a; hst_size = sz; hst_wdata = wd;
        @(negedge clk);
        hst_valid = 1'b0;
        while (q.size() != 0 || hst_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [1:0] sz,
                                          input logic [1:0] o, input logic [31:0] wd);
        int sh;
        logic [31:0] m;
        if (sz == 2'd0) begin sh = 8 * o;        m = 32'hFF;   end
        else            begin sh = 16 * int'(o[1]); m = 32'hFFFF; end
        return (old & ~(m << sh)) | ((wd & m) << sh);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [31:0] SELW = 32'h8012_AB7C;  // bus 0x12, dev 21, func 3, reg 31
    int c0;
    logic [31:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!hst_busy && !hst_done && !cfg_req_valid, "R1 reset outputs",
            {29'd0, hst_busy, hst_done, cfg_req_valid}, 32'd0);
        acc(0, 16'h0CF8, 2, 0, 1, 32'h0, 0, 0, "R1 selector reset value");

        // R2
        acc(1, 16'h0CF8, 2, 32'hFF12_AB7F, 1, 32'h0, 0, 0, "R2 selector write");
        acc(0, 16'h0CF8, 2, 0, 1, SELW, 0, 0, "R2 selector readback");

        // R3
        c0 = req_cnt;
        acc(0, 16'h0CFC, 2, 0, 1, exp_mem[31], 0, 1, "R3 dword read");
        chk(req_cnt == c0 + 1, "R3 one request", req_cnt, c0 + 1);
        chk({last_bus, last_dev, last_func, last_reg} == {8'h12, 5'd21, 3'd3, 6'd31},
            "R2 request fields", {8'h0, last_bus, last_dev, last_func, last_reg},
            {8'h0, 8'h12, 5'd21, 3'd3, 6'd31});

        // R4
        for (int k = 0; k < 4; k++) begin
            v = (exp_mem[31] >> (8 * k)) & 32'hFF;
            acc(0, 16'h0CFC + 16'(k), 0, 0, 1, v, 0, 1, "R4 byte read");
        end

        // R5
        acc(0, 16'h0CFC, 1, 0, 1, exp_mem[31] & 32'hFFFF, 0, 1, "R5 half read low");
        acc(0, 16'h0CFD, 1, 0, 1, exp_mem[31] & 32'hFFFF, 0, 1, "R5 half read bit0 ignored");
        acc(0, 16'h0CFE, 1, 0, 1, exp_mem[31] >> 16, 0, 1, "R5 half read high");

        // R6
        slow = 1'b1;
        c0 = req_cnt;
        acc(1, 16'h0CFC, 2, 32'hDEAD_BEEF, 1, 32'h0, 0, 2, "R6 dword write");
        exp_mem[31] = 32'hDEAD_BEEF;
        chk(req_cnt == c0 + 1, "R6 single request", req_cnt, c0 + 1);
        chk(tmem[31] == exp_mem[31], "R6 target dword", tmem[31], exp_mem[31]);

        // R7
        c0 = req_cnt;
        acc(1, 16'h0CFE, 0, 32'hFFFF_FF5A, 1, 32'h0, 0, 2, "R7 byte write");
        exp_mem[31] = merge(exp_mem[31], 0, 2, 32'hFFFF_FF5A);
        chk(req_cnt == c0 + 2, "R7 read then write", req_cnt, c0 + 2);
        chk(tmem[31] == exp_mem[31], "R7 byte merge", tmem[31], exp_mem[31]);
        acc(1, 16'h0CFC, 1, 32'hABCD_1234, 1, 32'h0, 0, 2, "R7 half write");
        exp_mem[31] = merge(exp_mem[31], 1, 0, 32'hABCD_1234);
        chk(tmem[31] == exp_mem[31], "R7 half merge", tmem[31], exp_mem[31]);
        acc(0, 16'h0CFC, 2, 0, 1, exp_mem[31], 0, 1, "R7 readback");

        // R10: intruding access while busy
        q.push_back('{32'h0, 1'b0, 2, "R10 partial write"});
        @(negedge clk);
        while (hst_busy) @(negedge clk);
        hst_valid = 1; hst_write = 1; hst_addr = 16'h0CFD; hst_size = 0; hst_wdata = 32'h77;
        @(negedge clk);
        chk(hst_busy, "R10 busy after accept", 32'(hst_busy), 32'd1);
        hst_addr = 16'h0CF8; hst_size = 2; hst_wdata = 32'h0;
        hst_valid = hst_busy;
        @(negedge clk);
        hst_valid = hst_busy;
        @(negedge clk);
        hst_valid = 1'b0;
        while (q.size() != 0 || hst_busy) @(negedge clk);
        repeat (2) @(negedge clk);
        exp_mem[31] = merge(exp_mem[31], 0, 1, 32'h77);
        chk(tmem[31] == exp_mem[31], "R10 merge intact", tmem[31], exp_mem[31]);
        acc(0, 16'h0CF8, 2, 0, 1, SELW, 0, 0, "R10 selector unchanged");
        slow = 1'b0;

        // R9
        c0 = req_cnt;
        acc(0, 16'h0CFD, 2, 0, 1, 32'h0, 1, 0, "R9 misaligned dword read");
        acc(1, 16'h0CFE, 2, 32'h1111_1111, 1, 32'h0, 1, 0, "R9 misaligned dword write");
        acc(0, 16'h0CFC, 3, 0, 1, 32'h0, 1, 0, "R9 size code 3");
        acc(1, 16'h0CF9, 0, 32'h0, 1, 32'h0, 1, 0, "R9 byte at address port");
        chk(req_cnt == c0, "R9 no request", req_cnt, c0);
        acc(0, 16'h0CF8, 2, 0, 1, SELW, 0, 0, "R9 selector unchanged");

        // R12
        acc(1, 16'h0CF0, 2, 32'h0, 0, 0, 0, 0, "R12 unmapped write");
        acc(0, 16'h0D00, 2, 0, 0, 0, 0, 0, "R12 unmapped read");
        chk(req_cnt == c0, "R12 no request", req_cnt, c0);
        acc(0, 16'h0CF8, 2, 0, 1, SELW, 0, 0, "R12 selector unchanged");

        // R8
        acc(1, 16'h0CF8, 2, SELW & 32'h7FFF_FFFF, 1, 32'h0, 0, 0, "R8 disable");
        c0 = req_cnt;
        acc(0, 16'h0CFC, 2, 0, 1, 32'hFFFF_FFFF, 0, 0, "R8 disabled read");
        acc(0, 16'h0CFF, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R8 disabled byte read");
        acc(1, 16'h0CFC, 2, 32'h0BAD_0BAD, 1, 32'h0, 0, 0, "R8 disabled write");
        chk(req_cnt == c0, "R8 no request", req_cnt, c0);
        acc(1, 16'h0CF8, 2, SELW, 1, 32'h0, 0, 0, "R8 re-enable");
        acc(0, 16'h0CFC, 2, 0, 1, exp_mem[31], 0, 1, "R8 write dropped");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule